// File: doc/BRIEF.md
# Resampling Phase Accumulator NCO

This block is the timing oscillator in front of a pulse-shaping filter and a polyphase interpolation filter. A 32-bit phase accumulator adds a 30-bit frequency word on every clock. Its top bit acts as the filters' input sample clock. The bits just below the top bit tell the filters where each new sample falls: a coarse field selects the shaping-filter phase and a fine field selects the interpolation phase. The resulting sample rate is word × f_clk / 2^32.

Software writes the frequency word in two halves into a holding buffer. The word becomes active only when a commit event occurs. A mode bit chooses the commit event: either an external sync pulse, or a write to the low-half address. After reset the accumulator is cleared and stays frozen. It starts again only after a sync pulse or a write to the high-half address. A two-stage synchronizer inside the block releases the reset.

Top module: `resamp_nco`

## Requirements
- R1: While reset is applied, and in the cycles after it is released, `smp_stb`, `coarse_ph` and `fine_ph` are all 0.
- R2: A write to address 2 loads buffer bits [15:0] from `wr_data[15:0]`. A write to address 3 loads buffer bits [29:16] from `wr_data[13:0]`, and `wr_data[15:14]` at address 3 are ignored.
- R3: A write to address 22 sets the commit mode from `wr_data[0]`. Value 0 means the sync pulse commits and a low-half write does not. Value 1 means a write to address 2 commits and the sync pulse does not.
- R4: Buffer writes do not change the rate in use until a commit event occurs.
- R5: While enabled, the accumulator adds the active word on every clock, modulo 2^32. Over 128 clocks starting from 0, the number of strobes is floor((128·word + 2^31) / 2^32).
- R6: `smp_stb` is high for exactly one cycle. It rises in the cycle that follows the clock edge on which accumulator bit 31 went from 0 to 1.
- R7: On each strobe edge, `coarse_ph` takes accumulator bits [30:27] and `fine_ph` takes bits [26:15] of the new accumulator value. Both fields hold their values between strobes.
- R8: After reset the accumulator does not advance until a sync pulse or a write to address 3 occurs. Either event enables it in both modes, and the enable stays set until the next reset.
- R9: If a sync pulse and a commit-mode write happen in the same cycle, the word is committed once. The committed value includes that cycle's buffer write.
- R10: Reset clears the buffer, the active word, the enable and the accumulator, so a commit made right after reset loads a word of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Register write address |
| wr_data | input | 16 | Register write data |
| sync_in | input | 1 | External sync pulse, one cycle |
| smp_stb | output | 1 | Sample-clock strobe |
| coarse_ph | output | 4 | Shaping-filter phase |
| fine_ph | output | 12 | Interpolation-filter phase |

## Verification
The bench builds the block with its default parameters: a 30-bit word, a 32-bit accumulator, a 16-bit write port and a 4/12 phase split. At this size, words between 2^25 and 2^29 give strobe periods of a few cycles. A sweep over sixteen such words, alternating between the two commit modes, therefore checks the exact strobe count and phase values in a short run. A word of 0xFFFF puts the first crossing of the top bit at clock 32769. That makes it possible to show, within the cycle budget, both that a disabled accumulator stays frozen and that a sync pulse restarts it.

// File: rtl/resamp_nco_pkg.sv
package resamp_nco_pkg;
  typedef enum logic {
    COMMIT_ON_SYNC  = 1'b0,
    COMMIT_ON_WRITE = 1'b1
  } commit_src_e;
endpackage

// File: rtl/resamp_nco_rstsync.sv
module resamp_nco_rstsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sh_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= 1'b1;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= {sh_q[STAGES-2:0], 1'b1};
      end
    end
  endgenerate

  assign rst_sync_n = sh_q[STAGES-1];
endmodule

// File: rtl/resamp_nco_regs.sv
module resamp_nco_regs
  import resamp_nco_pkg::*;
#(
  parameter int FW_W      = 30,
  parameter int DW        = 16,
  parameter int AW        = 5,
  parameter int ADDR_LO   = 2,
  parameter int ADDR_HI   = 3,
  parameter int ADDR_MODE = 22
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [AW-1:0]   wr_addr,
  input  logic [DW-1:0]   wr_data,
  input  logic            sync_in,
  output logic [FW_W-1:0] act_word,
  output logic [FW_W-1:0] buf_word,
  output commit_src_e     mode,
  output logic            run_en
);
  localparam int HI_W = FW_W - DW;

  logic [FW_W-1:0] buf_q, buf_nx, act_q, act_nx;
  commit_src_e     mode_q, mode_nx;
  logic            en_q, en_nx;
  logic            wr_lo, wr_hi, wr_mode, commit;

  assign wr_lo   = wr_en && (wr_addr == AW'(ADDR_LO));
  assign wr_hi   = wr_en && (wr_addr == AW'(ADDR_HI));
  assign wr_mode = wr_en && (wr_addr == AW'(ADDR_MODE));

  // next state: buffer first, so a same-cycle commit sees this cycle's write
  always_comb begin
    buf_nx = buf_q;
    if (wr_lo) buf_nx[DW-1:0]    = wr_data;
    if (wr_hi) buf_nx[FW_W-1:DW] = wr_data[HI_W-1:0];

    mode_nx = mode_q;
    if (wr_mode) mode_nx = commit_src_e'(wr_data[0]);

    commit = (mode_q == COMMIT_ON_WRITE) ? wr_lo : sync_in;
    act_nx = commit ? buf_nx : act_q;

    en_nx = en_q | sync_in | wr_hi;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q  <= '0;
      act_q  <= '0;
      mode_q <= COMMIT_ON_SYNC;
      en_q   <= 1'b0;
    end else begin
      if (wr_lo || wr_hi) buf_q  <= buf_nx;
      if (commit)         act_q  <= act_nx;
      if (wr_mode)        mode_q <= mode_nx;
      if (!en_q)          en_q   <= en_nx;
    end
  end

  assign act_word = act_q;
  assign buf_word = buf_q;
  assign mode     = mode_q;
  assign run_en   = en_q;
endmodule

// File: rtl/resamp_nco_acc.sv
module resamp_nco_acc #(
  parameter int FW_W     = 30,
  parameter int ACC_W    = 32,
  parameter int COARSE_W = 4,
  parameter int FINE_W   = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                run_en,
  input  logic [FW_W-1:0]     freq,
  output logic [ACC_W-1:0]    acc,
  output logic                stb,
  output logic [COARSE_W-1:0] coarse,
  output logic [FINE_W-1:0]   fine
);
  localparam int MSB  = ACC_W - 1;
  localparam int C_LO = MSB - COARSE_W;
  localparam int F_LO = C_LO - FINE_W;
  localparam int PADW = ACC_W - FW_W;

  logic [ACC_W-1:0]    acc_q, acc_nx;
  logic                stb_q, rise;
  logic [COARSE_W-1:0] co_q;
  logic [FINE_W-1:0]   fi_q;

  always_comb begin
    acc_nx = acc_q + {{PADW{1'b0}}, freq};
    rise   = run_en && !acc_q[MSB] && acc_nx[MSB];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      stb_q <= 1'b0;
      co_q  <= '0;
      fi_q  <= '0;
    end else begin
      if (run_en) acc_q <= acc_nx;
      stb_q <= rise;
      if (rise) begin
        co_q <= acc_nx[MSB-1:C_LO];
        fi_q <= acc_nx[C_LO-1:F_LO];
      end
    end
  end

  assign acc    = acc_q;
  assign stb    = stb_q;
  assign coarse = co_q;
  assign fine   = fi_q;
endmodule

// File: rtl/resamp_nco.sv
module resamp_nco
  import resamp_nco_pkg::*;
#(
  parameter int FW_W       = 30,
  parameter int ACC_W      = 32,
  parameter int COARSE_W   = 4,
  parameter int FINE_W     = 12,
  parameter int DW         = 16,
  parameter int AW         = 5,
  parameter int ADDR_LO    = 2,
  parameter int ADDR_HI    = 3,
  parameter int ADDR_MODE  = 22,
  parameter int RST_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [AW-1:0]       wr_addr,
  input  logic [DW-1:0]       wr_data,
  input  logic                sync_in,
  output logic                smp_stb,
  output logic [COARSE_W-1:0] coarse_ph,
  output logic [FINE_W-1:0]   fine_ph
);
  logic             rst_sync_n;
  logic [FW_W-1:0]  act_word, buf_word;
  commit_src_e      mode;
  logic             run_en;
  logic [ACC_W-1:0] acc;

  resamp_nco_rstsync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  resamp_nco_regs #(
    .FW_W(FW_W), .DW(DW), .AW(AW),
    .ADDR_LO(ADDR_LO), .ADDR_HI(ADDR_HI), .ADDR_MODE(ADDR_MODE)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .sync_in  (sync_in),
    .act_word (act_word),
    .buf_word (buf_word),
    .mode     (mode),
    .run_en   (run_en)
  );

  resamp_nco_acc #(
    .FW_W(FW_W), .ACC_W(ACC_W), .COARSE_W(COARSE_W), .FINE_W(FINE_W)
  ) u_acc (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .run_en (run_en),
    .freq   (act_word),
    .acc    (acc),
    .stb    (smp_stb),
    .coarse (coarse_ph),
    .fine   (fine_ph)
  );
endmodule

// File: rtl/resamp_nco_chk.sv
module resamp_nco_chk
  import resamp_nco_pkg::*;
#(
  parameter int FW_W      = 30,
  parameter int ACC_W     = 32,
  parameter int COARSE_W  = 4,
  parameter int FINE_W    = 12,
  parameter int AW        = 5,
  parameter int ADDR_LO   = 2,
  parameter int ADDR_HI   = 3
) (
  input logic                clk,
  input logic                rst_n,
  input logic                wr_en,
  input logic [AW-1:0]       wr_addr,
  input logic                sync_in,
  input commit_src_e         mode,
  input logic [FW_W-1:0]     act_word,
  input logic [FW_W-1:0]     buf_word,
  input logic                run_en,
  input logic [ACC_W-1:0]    acc,
  input logic                smp_stb,
  input logic [COARSE_W-1:0] coarse_ph,
  input logic [FINE_W-1:0]   fine_ph
);
  localparam int MSB  = ACC_W - 1;
  localparam int C_LO = MSB - COARSE_W;
  localparam int F_LO = C_LO - FINE_W;

  logic lo_w, hi_w;
  assign lo_w = wr_en && (wr_addr == AW'(ADDR_LO));
  assign hi_w = wr_en && (wr_addr == AW'(ADDR_HI));

  p_sync_commit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == COMMIT_ON_SYNC && sync_in) |=> (act_word == buf_word));

  p_write_commit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == COMMIT_ON_WRITE && lo_w) |=> (act_word == buf_word));

  p_sync_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == COMMIT_ON_WRITE && sync_in && !lo_w) |=> $stable(act_word));

  p_no_event_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!sync_in && !lo_w) |=> $stable(act_word));

  p_halt_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> $stable(acc));

  p_stay_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_en && !sync_in && !hi_w) |=> !run_en);

  p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    run_en |=> run_en);

  p_strobe_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
    smp_stb |-> (acc[MSB] && !$past(acc[MSB])));

  p_strobe_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    smp_stb |=> !smp_stb);

  p_phase_match_r7: assert property (@(posedge clk) disable iff (!rst_n)
    smp_stb |-> (coarse_ph == acc[MSB-1:C_LO] && fine_ph == acc[C_LO-1:F_LO]));

  p_phase_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_stb |-> ($stable(coarse_ph) && $stable(fine_ph)));

  always @(posedge clk) begin
    if (rst_n === 1'b0) begin
      p_reset_clear_r10: assert (acc == '0 && act_word == '0 && buf_word == '0
                                 && !run_en && !smp_stb);
    end
  end
endmodule

bind resamp_nco resamp_nco_chk #(
  .FW_W(FW_W), .ACC_W(ACC_W), .COARSE_W(COARSE_W), .FINE_W(FINE_W),
  .AW(AW), .ADDR_LO(ADDR_LO), .ADDR_HI(ADDR_HI)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .wr_en     (wr_en),
  .wr_addr   (wr_addr),
  .sync_in   (sync_in),
  .mode      (mode),
  .act_word  (act_word),
  .buf_word  (buf_word),
  .run_en    (run_en),
  .acc       (acc),
  .smp_stb   (smp_stb),
  .coarse_ph (coarse_ph),
  .fine_ph   (fine_ph)
);

// File: tb/tb_resamp_nco.sv
module tb_resamp_nco;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 190000;
  localparam logic [4:0] AD_LO   = 5'd2;
  localparam logic [4:0] AD_HI   = 5'd3;
  localparam logic [4:0] AD_MODE = 5'd22;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        sync_in = 1'b0;
  logic        smp_stb;
  logic [3:0]  coarse_ph;
  logic [11:0] fine_ph;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done   = 1'b0;

  // bench expectation state, set by each test from the requirements
  logic [31:0] b_acc = '0;
  logic [29:0] b_sr  = '0;
  logic        b_en  = 1'b0;
  logic [3:0]  exp_co = '0;
  logic [11:0] exp_fi = '0;
  int          stb_seen = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  resamp_nco dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .sync_in(sync_in), .smp_stb(smp_stb),
    .coarse_ph(coarse_ph), .fine_ph(fine_ph)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step(input logic we, input logic [4:0] a, input logic [15:0] d,
                      input logic sy, input logic [29:0] sr_after,
                      input logic en_after, input string tag);
    logic [31:0] prev;
    logic        rise;
    wr_en = we; wr_addr = a; wr_data = d; sync_in = sy;
    @(posedge clk);
    prev = b_acc;
    if (b_en) b_acc = b_acc + {2'b00, b_sr};
    rise = b_en && !prev[31] && b_acc[31];
    b_sr = sr_after;
    b_en = en_after;
    if (rise) begin
      exp_co = b_acc[30:27];
      exp_fi = b_acc[26:15];
    end
    @(negedge clk);
    wr_en = 1'b0; sync_in = 1'b0;
    if (smp_stb === 1'b1) stb_seen++;
    chk(smp_stb === rise, tag, "R6 strobe", longint'(smp_stb), longint'(rise));
    chk(coarse_ph === exp_co && fine_ph === exp_fi, tag, "R7 phase",
        {coarse_ph, fine_ph}, {exp_co, exp_fi});
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(1'b0, 5'd0, 16'd0, 1'b0, b_sr, b_en, tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; wr_en = 1'b0; sync_in = 1'b0;
    repeat (3) @(negedge clk);
    chk(smp_stb === 1'b0 && coarse_ph === 4'd0 && fine_ph === 12'd0, "R1",
        "outputs in reset", {smp_stb, coarse_ph, fine_ph}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(smp_stb === 1'b0 && coarse_ph === 4'd0 && fine_ph === 12'd0, "R1",
        "outputs after release", {smp_stb, coarse_ph, fine_ph}, 0);
    b_acc = '0; b_sr = '0; b_en = 1'b0; exp_co = '0; exp_fi = '0;
  endtask

  function automatic longint exp_rises(input logic [29:0] sr, input int n);
    longint unsigned t;
    t = longint'(n) * longint'(sr) + 64'h8000_0000;
    return longint'(t >> 32);
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog expired after %0d cycles", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [29:0] sr, sra, srb;
    int c0;

    do_reset();

    // sweep over sixteen words, alternating the commit mode
    for (int k = 0; k < 16; k++) begin
      sr = 30'(((k + 1) << 25) + k * 'h1357);
      do_reset();
      if (k % 2 == 0) begin
        step(1'b1, AD_LO, sr[15:0], 1'b0, 30'd0, 1'b0, "R5");
        step(1'b1, AD_HI, {2'b00, sr[29:16]}, 1'b0, 30'd0, 1'b1, "R8");
        step(1'b0, 5'd0, 16'd0, 1'b1, sr, 1'b1, "R3");
      end else begin
        step(1'b1, AD_MODE, 16'd1, 1'b0, 30'd0, 1'b0, "R3");
        step(1'b1, AD_HI, {2'b11, sr[29:16]}, 1'b0, 30'd0, 1'b1, "R2");
        step(1'b1, AD_LO, sr[15:0], 1'b0, sr, 1'b1, "R3");
      end
      c0 = stb_seen;
      idle(128, "R5");
      chk(longint'(stb_seen - c0) == exp_rises(sr, 128), "R5", "strobe count",
          stb_seen - c0, exp_rises(sr, 128));
    end

    // R4: buffered writes without a commit leave the rate alone
    sra = 30'h0C00_1234;
    srb = 30'h2123_0000;
    do_reset();
    step(1'b1, AD_LO, sra[15:0], 1'b0, 30'd0, 1'b0, "R4");
    step(1'b1, AD_HI, {2'b00, sra[29:16]}, 1'b0, 30'd0, 1'b1, "R4");
    step(1'b0, 5'd0, 16'd0, 1'b1, sra, 1'b1, "R4");
    idle(50, "R4");
    step(1'b1, AD_LO, srb[15:0], 1'b0, sra, 1'b1, "R4");
    step(1'b1, AD_HI, {2'b00, srb[29:16]}, 1'b0, sra, 1'b1, "R4");
    idle(50, "R4");
    step(1'b0, 5'd0, 16'd0, 1'b1, srb, 1'b1, "R4");
    idle(50, "R4");

    // R3: in write mode a sync pulse and a high-half write do not commit
    step(1'b1, AD_MODE, 16'd1, 1'b0, srb, 1'b1, "R3");
    step(1'b1, AD_HI, 16'h0F00, 1'b0, srb, 1'b1, "R3");
    step(1'b0, 5'd0, 16'd0, 1'b1, srb, 1'b1, "R3");
    idle(30, "R3");
    step(1'b1, AD_LO, srb[15:0], 1'b0, {14'h0F00, srb[15:0]}, 1'b1, "R3");
    idle(60, "R3");

    // R9: sync and low-half write together commit the written value once
    do_reset();
    step(1'b1, AD_LO, 16'h1111, 1'b0, 30'd0, 1'b0, "R9");
    step(1'b1, AD_HI, 16'h1800, 1'b0, 30'd0, 1'b1, "R9");
    step(1'b1, AD_LO, 16'h2222, 1'b1, {14'h1800, 16'h2222}, 1'b1, "R9");
    idle(60, "R9");

    // R10: reset clears buffer and active word; a bare commit loads zero
    do_reset();
    step(1'b0, 5'd0, 16'd0, 1'b1, 30'd0, 1'b1, "R10");
    c0 = stb_seen;
    idle(64, "R10");
    chk(stb_seen == c0, "R10", "strobes after zero commit", stb_seen - c0, 0);

    // R8: a committed but disabled word does not run; sync restarts it
    do_reset();
    step(1'b1, AD_MODE, 16'd1, 1'b0, 30'd0, 1'b0, "R8");
    step(1'b1, AD_LO, 16'hFFFF, 1'b0, 30'h0000_FFFF, 1'b0, "R8");
    c0 = stb_seen;
    idle(40000, "R8");
    chk(stb_seen == c0, "R8", "strobes while halted", stb_seen - c0, 0);
    step(1'b0, 5'd0, 16'd0, 1'b1, 30'h0000_FFFF, 1'b1, "R8");
    c0 = stb_seen;
    idle(33000, "R8");
    chk(stb_seen - c0 == 1, "R8", "strobes after sync restart", stb_seen - c0, 1);

    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule